// File: doc/BRIEF.md
# Voltage Alarm Control and Status Register

This block is the digital side of a window voltage monitor. An analog comparator pair drives two asynchronous level signals into it, one that goes high when the monitored supply drops below its lower threshold and one that goes high when it rises above its upper threshold. The block retimes both signals into the core clock domain and shows them as read-only status bits. When an enabled condition is active, it latches a sticky interrupt flag. It drives an interrupt line gated by a master enable. It also holds a power-down bit that is sent to the analog part.

Software reaches the block through one 8-bit register on a simple synchronous port. A select and a write strobe perform a byte write, and the read data is combinational while the port is selected. A sideband flag marks read-modify-write accesses. During such an access the interrupt flag position reads back as 1. Writing the read value back therefore never clears a pending request. The flag is cleared only by writing 0 to it. A condition that is still active and enabled sets it again on every cycle, so a clear in the same cycle has no effect. To clear a flag caused by a persistent fault, software first disables that condition's enable bit and then clears the flag in a later write.

Top module: `volt_alarm_ctrl`

## Requirements
- R1: Each comparator input passes through two flip-flop stages. A change on an input appears in its status bit after the second rising clock edge, and not after the first.
- R2: Register bit 4 shows the retimed undervoltage level and bit 3 shows the retimed overvoltage level (1 = condition present). Writes to these bits have no effect.
- R3: The interrupt flag (bit 2) is cleared by a register write with bit 2 = 0. A write with bit 2 = 1 leaves the flag unchanged.
- R4: While busSel and busRmw are both 1, busRdata bit 2 reads 1 whatever the flag holds.
- R5: If a clearing write and an enabled alarm condition occur in the same cycle, the flag is 1 after that edge.
- R6: Bit 6 enables undervoltage and bit 5 enables overvoltage interrupt generation. An active level whose enable is 1 sets the flag on every cycle, so a clear succeeds only in a write after the edge that cleared the enable.
- R7: Bit 1 is the interrupt enable. irqOut is 1 exactly when the flag and bit 1 are both 1.
- R8: Bit 0 is power-down and drives powerDown. While it is 1, both status levels read 0 and raise no interrupt.
- R9: After reset every register bit, the flag, irqOut and powerDown are 0.
- R10: Bit 7 always reads 0, and busRdata is 0 while busSel is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| uvAsync | input | 1 | Undervoltage comparator level, asynchronous |
| ovAsync | input | 1 | Overvoltage comparator level, asynchronous |
| busSel | input | 1 | Register select |
| busWr | input | 1 | Write strobe, valid with busSel |
| busRmw | input | 1 | Marks the access as read-modify-write |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational |
| irqOut | output | 1 | Gated interrupt request |
| powerDown | output | 1 | Power-down request to the analog part |

## Verification
The assertions assume the bus strobes and write data are steady for the whole clock cycle around each rising edge. They also assume the comparator inputs are single-bit levels whose only timing relation to the clock comes through the synchronizer. The bench changes every input at the falling edge and samples at the falling edge before it drives the next values. Comparator inputs change on only about one cycle in eight, so alarm conditions persist across clears and enable changes as a real supply fault would.

// File: rtl/volt_alarm_pkg.sv
package volt_alarm_pkg;
  localparam int REG_W      = 8;
  localparam int PD_BIT     = 0;
  localparam int IEN_BIT    = 1;
  localparam int IRQ_BIT    = 2;
  localparam int OV_LVL_BIT = 3;
  localparam int UV_LVL_BIT = 4;
  localparam int OV_EN_BIT  = 5;
  localparam int UV_EN_BIT  = 6;

  typedef struct packed {
    logic cfgWrite;
    logic irqClear;
    logic rmwRead;
    logic readEn;
    logic uvEnNext;
    logic ovEnNext;
    logic irqEnNext;
    logic pdNext;
  } ctrlStrobes_t;
endpackage

// File: rtl/va_sync.sv
module va_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [STAGES-1:0][WIDTH-1:0] stageQ;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : gStage
      if (s == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[0] <= '0;
          else       stageQ[0] <= asyncIn;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/va_ctrl.sv
module va_ctrl
  import volt_alarm_pkg::*;
(
  input  logic             busSel,
  input  logic             busWr,
  input  logic             busRmw,
  input  logic [REG_W-1:0] busWdata,
  output ctrlStrobes_t     strobes
);
  logic wrHit;
  logic unused_wdataBits;

  assign wrHit = busSel & busWr;
  assign unused_wdataBits = &{1'b0, busWdata[REG_W-1], busWdata[UV_LVL_BIT], busWdata[OV_LVL_BIT]};

  always_comb begin
    strobes.cfgWrite  = wrHit;
    strobes.irqClear  = wrHit & ~busWdata[IRQ_BIT];
    strobes.rmwRead   = busSel & busRmw;
    strobes.readEn    = busSel;
    strobes.uvEnNext  = busWdata[UV_EN_BIT];
    strobes.ovEnNext  = busWdata[OV_EN_BIT];
    strobes.irqEnNext = busWdata[IEN_BIT];
    strobes.pdNext    = busWdata[PD_BIT];
  end
endmodule

// File: rtl/va_datapath.sv
module va_datapath
  import volt_alarm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             uvAsync,
  input  logic             ovAsync,
  input  ctrlStrobes_t     strobes,
  output logic [REG_W-1:0] busRdata,
  output logic             irqOut,
  output logic             powerDown,
  output logic             irqFlag,
  output logic             uvLvl,
  output logic             ovLvl,
  output logic             uvEn,
  output logic             ovEn
);
  localparam int NUM_COND = 2;

  logic [NUM_COND-1:0] syncLvl;
  logic                irqEn;
  logic                pdQ;
  logic                alarmEvent;
  logic [REG_W-1:0]    regView;

  va_sync #(.WIDTH(NUM_COND), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({uvAsync, ovAsync}),
    .syncOut (syncLvl)
  );

  assign uvLvl = syncLvl[1] & ~pdQ;
  assign ovLvl = syncLvl[0] & ~pdQ;

  assign alarmEvent = (uvLvl & uvEn) | (ovLvl & ovEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      uvEn  <= 1'b0;
      ovEn  <= 1'b0;
      irqEn <= 1'b0;
      pdQ   <= 1'b0;
    end else if (strobes.cfgWrite) begin
      uvEn  <= strobes.uvEnNext;
      ovEn  <= strobes.ovEnNext;
      irqEn <= strobes.irqEnNext;
      pdQ   <= strobes.pdNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 irqFlag <= 1'b0;
    else if (alarmEvent)       irqFlag <= 1'b1;
    else if (strobes.irqClear) irqFlag <= 1'b0;
  end

  always_comb begin
    regView             = '0;
    regView[PD_BIT]     = pdQ;
    regView[IEN_BIT]    = irqEn;
    regView[IRQ_BIT]    = irqFlag | strobes.rmwRead;
    regView[OV_LVL_BIT] = ovLvl;
    regView[UV_LVL_BIT] = uvLvl;
    regView[OV_EN_BIT]  = ovEn;
    regView[UV_EN_BIT]  = uvEn;
  end

  assign busRdata  = strobes.readEn ? regView : '0;
  assign irqOut    = irqFlag & irqEn;
  assign powerDown = pdQ;
endmodule

// File: rtl/volt_alarm_ctrl.sv
module volt_alarm_ctrl
  import volt_alarm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             uvAsync,
  input  logic             ovAsync,
  input  logic             busSel,
  input  logic             busWr,
  input  logic             busRmw,
  input  logic [REG_W-1:0] busWdata,
  output logic [REG_W-1:0] busRdata,
  output logic             irqOut,
  output logic             powerDown
);
  ctrlStrobes_t strobes;
  logic irqFlag, uvLvl, ovLvl, uvEn, ovEn;

  va_ctrl u_ctrl (
    .busSel   (busSel),
    .busWr    (busWr),
    .busRmw   (busRmw),
    .busWdata (busWdata),
    .strobes  (strobes)
  );

  va_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .uvAsync   (uvAsync),
    .ovAsync   (ovAsync),
    .strobes   (strobes),
    .busRdata  (busRdata),
    .irqOut    (irqOut),
    .powerDown (powerDown),
    .irqFlag   (irqFlag),
    .uvLvl     (uvLvl),
    .ovLvl     (ovLvl),
    .uvEn      (uvEn),
    .ovEn      (ovEn)
  );
endmodule

// File: rtl/volt_alarm_ctrl_chk.sv
module volt_alarm_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busSel,
  input logic       busWr,
  input logic       busRmw,
  input logic [7:0] busWdata,
  input logic [7:0] busRdata,
  input logic       irqOut,
  input logic       powerDown,
  input logic       irqFlag,
  input logic       uvLvl,
  input logic       ovLvl,
  input logic       uvEn,
  input logic       ovEn
);
  AST_RMW_READS_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busRmw) |-> busRdata[2]); // R4

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busRmw) |-> (irqOut == (busRdata[2] && busRdata[1]))); // R7

  AST_PD_MUTES_LEVELS: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && powerDown) |-> (busRdata[4:3] == 2'b00)); // R8

  AST_PD_MATCHES_BIT: assert property (@(posedge clk) disable iff (!rstN)
    busSel |-> (busRdata[0] == powerDown)); // R8

  AST_IRQ_FALL_NEEDS_W0: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqFlag) |-> $past(busSel && busWr && !busWdata[2])); // R3

  AST_IRQ_RISE_NEEDS_ALARM: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> $past((uvLvl && uvEn) || (ovLvl && ovEn))); // R6

  AST_ALARM_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    ((uvLvl && uvEn) || (ovLvl && ovEn)) |=> irqFlag); // R5

  AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !busRdata[7]); // R10

  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |-> (busRdata == 8'h00)); // R10
endmodule

bind volt_alarm_ctrl volt_alarm_ctrl_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busSel    (busSel),
  .busWr     (busWr),
  .busRmw    (busRmw),
  .busWdata  (busWdata),
  .busRdata  (busRdata),
  .irqOut    (irqOut),
  .powerDown (powerDown),
  .irqFlag   (irqFlag),
  .uvLvl     (uvLvl),
  .ovLvl     (ovLvl),
  .uvEn      (uvEn),
  .ovEn      (ovEn)
);

// File: tb/volt_alarm_ctrl_tb.sv
module volt_alarm_ctrl_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       uvAsync = 1'b0, ovAsync = 1'b0;
  logic       busSel = 1'b0, busWr = 1'b0, busRmw = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic       irqOut, powerDown;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  volt_alarm_ctrl u_dut (
    .clk(clk), .rstN(rstN), .uvAsync(uvAsync), .ovAsync(ovAsync),
    .busSel(busSel), .busWr(busWr), .busRmw(busRmw), .busWdata(busWdata),
    .busRdata(busRdata), .irqOut(irqOut), .powerDown(powerDown)
  );

  // Reference model built from the requirements
  logic [1:0] mS1, mS2;
  logic mIrq, mUvEn, mOvEn, mIen, mPd;

  function automatic logic mUv(); return mS2[1] & ~mPd; endfunction
  function automatic logic mOv(); return mS2[0] & ~mPd; endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS1 <= 2'b00; mS2 <= 2'b00; mIrq <= 1'b0;
      mUvEn <= 1'b0; mOvEn <= 1'b0; mIen <= 1'b0; mPd <= 1'b0;
    end else begin
      mS1 <= {uvAsync, ovAsync};
      mS2 <= mS1;
      if ((mUv() && mUvEn) || (mOv() && mOvEn)) mIrq <= 1'b1;
      else if (busSel && busWr && !busWdata[2]) mIrq <= 1'b0;
      if (busSel && busWr) begin
        mUvEn <= busWdata[6]; mOvEn <= busWdata[5];
        mIen <= busWdata[1]; mPd <= busWdata[0];
      end
    end
  end

  function automatic logic [7:0] expRd();
    if (!busSel) return 8'h00;
    return {1'b0, mUvEn, mOvEn, mUv(), mOv(), mIrq | busRmw, mIen, mPd};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Full comparison of all outputs against the model, tagged by field
  task automatic cmpAll();
    logic [7:0] e;
    e = expRd();
    if (!busSel) chk("R10 idle read", busRdata, 8'h00);
    else begin
      chk("R10 bit7", {7'd0, busRdata[7]}, {7'd0, e[7]});
      chk("R6 enables", {6'd0, busRdata[6:5]}, {6'd0, e[6:5]});
      chk("R2 levels", {6'd0, busRdata[4:3]}, {6'd0, e[4:3]});
      chk(busRmw ? "R4 rmw flag" : "R3 flag", {7'd0, busRdata[2]}, {7'd0, e[2]});
      chk("R7 enable bit", {7'd0, busRdata[1]}, {7'd0, e[1]});
      chk("R8 pd bit", {7'd0, busRdata[0]}, {7'd0, e[0]});
    end
    chk("R7 irqOut", {7'd0, irqOut}, {7'd0, mIrq & mIen});
    chk("R8 powerDown", {7'd0, powerDown}, {7'd0, mPd});
  endtask

  // At a falling edge: drive, wait one rising edge, compare at next falling edge
  task automatic step(input logic sel, input logic wr, input logic rmw,
                      input logic [7:0] wd, input logic uv, input logic ov);
    busSel = sel; busWr = wr; busRmw = rmw; busWdata = wd;
    uvAsync = uv; ovAsync = ov;
    @(posedge clk);
    @(negedge clk);
    busWr = 1'b0;
    cmpAll();
  endtask

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    busSel = 1'b1;
    #1;
    chk("R9 reset read", busRdata, 8'h00);
    chk("R9 reset irqOut", {7'd0, irqOut}, 8'h00);
    chk("R9 reset powerDown", {7'd0, powerDown}, 8'h00);
    rstN = 1'b1;
    @(negedge clk);

    // R1: two-stage retiming of the undervoltage level
    step(1, 1, 0, 8'h04, 0, 0);
    step(1, 0, 0, 8'h00, 1, 0);
    chk("R1 after one edge", {7'd0, busRdata[4]}, 8'h00);
    step(1, 0, 0, 8'h00, 1, 0);
    chk("R1 after two edges", {7'd0, busRdata[4]}, 8'h01);

    // R4: rmw read shows 1 while flag is 0
    step(1, 0, 1, 8'h00, 1, 0);
    chk("R4 rmw read", {7'd0, busRdata[2]}, 8'h01);

    // R6/R5: enable undervoltage and interrupts, flag sets, clear loses
    step(1, 1, 0, 8'h42, 1, 0);
    step(1, 0, 0, 8'h00, 1, 0);
    chk("R6 flag set", {7'd0, busRdata[2]}, 8'h01);
    chk("R7 irqOut high", {7'd0, irqOut}, 8'h01);
    step(1, 1, 0, 8'h42, 1, 0);
    chk("R5 alarm beats clear", {7'd0, busRdata[2]}, 8'h01);
    // R3: write 1 keeps flag
    step(1, 1, 0, 8'h46, 1, 0);
    chk("R3 write one keeps", {7'd0, busRdata[2]}, 8'h01);
    // R6: disabling and clearing in one write still loses; next clear wins
    step(1, 1, 0, 8'h02, 1, 0);
    chk("R6 same-write clear", {7'd0, busRdata[2]}, 8'h01);
    step(1, 1, 0, 8'h02, 1, 0);
    chk("R6 later clear", {7'd0, busRdata[2]}, 8'h00);
    chk("R7 irqOut low", {7'd0, irqOut}, 8'h00);

    // R8: power-down mutes levels
    step(1, 1, 0, 8'h61, 1, 1);
    step(1, 0, 0, 8'h00, 1, 1);
    chk("R8 powerDown high", {7'd0, powerDown}, 8'h01);
    chk("R8 levels muted", {6'd0, busRdata[4:3]}, 8'h00);
    chk("R8 no alarm in pd", {7'd0, busRdata[2]}, 8'h00);
    step(0, 0, 0, 8'h00, 1, 1);
    chk("R10 unselected", busRdata, 8'h00);

    // Constrained random phase
    begin
      logic uv, ov;
      uv = 1'b0; ov = 1'b0;
      for (int i = 0; i < 4000; i++) begin
        if ($urandom_range(7) == 0) uv = ~uv;
        if ($urandom_range(7) == 0) ov = ~ov;
        step(($urandom_range(3) != 0), ($urandom_range(2) == 0),
             ($urandom_range(4) == 0), 8'($urandom()), uv, ov);
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule